// File: doc/BRIEF.md
# Fuse-Programmed AND-OR Logic Array

This block models a small programmable sum-of-products array. A map of 2048 fuse bits, loaded one bit per clock through a configuration port, decides which literals each product term keeps. Ten dedicated inputs and six feedback signals reach the array. Each of these sixteen signals is offered in true and in inverted form, so every product term has 32 candidate literals. The 64 product terms are split into eight groups of eight, one group per output.

Within a group, the first term does not take part in the logic function. It acts as that output's private drive enable. The other seven terms are ORed together and the result is inverted, so each output is active-low. Outputs 1 to 6 model bidirectional pins. The level on each of those pins is fed back into the array. That level is the block's own driven value when the output is enabled and the externally applied value when it is not. Outputs 0 and 7 have no feedback. Once the map is loaded, the whole array is combinational from the pins to the outputs.

Top module: `pal_array`

## Requirements
- R1: While reset is asserted and after it is released, every fuse is intact until it is written. With all fuses intact, every `out_en` bit is 0 and every `out_val` bit is 1.
- R2: When `cfg_we` is 1 at a rising clock edge, the fuse at `cfg_addr` takes the value `cfg_bit`, where 1 means blown and 0 means intact (restored). The new value affects the outputs right after that edge. When `cfg_we` is 0, the fuse map does not change, whatever `cfg_addr` and `cfg_bit` carry.
- R3: Fuse index = row × 32 + column, with row = output × 8 + term (term 0 to 7). Column 2s is the true literal of signal s and column 2s+1 is its complement. Signals 0 to 9 are `in_pins[0..9]`, and signal 9+j is the feedback of output j for j = 1 to 6.
- R4: A product term is the AND of the literals whose fuses are intact. If both literals of the same signal are intact, the term is 0. If all 32 fuses of the term are blown, the term is 1.
- R5: Term 0 of output j's group drives `out_en[j]` directly.
- R6: `out_val[j]` is the inverse of the OR of terms 1 to 7 of output j's group.
- R7: For output j from 1 to 6, the feedback signal equals `out_val[j]` when `out_en[j]` is 1 and equals `io_in[j-1]` when `out_en[j]` is 0.
- R8: A change on `in_pins` or `io_in` reaches `out_val` and `out_en` within the same cycle, with no clock edge needed.
- R9: Chains of up to six feedback links, in which one output's term uses the feedback of another, resolve to their settled levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for fuse writes |
| rst_n | input | 1 | Asynchronous active-low reset; restores every fuse to intact |
| cfg_we | input | 1 | Fuse write strobe |
| cfg_addr | input | 11 | Fuse index to write |
| cfg_bit | input | 1 | Value written: 1 blown, 0 intact |
| in_pins | input | 10 | Dedicated array inputs |
| io_in | input | 6 | Externally applied levels on the pins of outputs 1 to 6 |
| out_val | output | 8 | Active-low logic value of each output |
| out_en | output | 8 | Drive enable of each output |

## Verification
Every logic result is combinational from `in_pins` and `io_in`, so it is due in the same cycle as the stimulus. A fuse write is due right after the rising edge that captures it. The bench drives all inputs on the falling edge. Its driver pushes each expected `out_val`/`out_en` pair into a queue, and the monitor pops and compares that pair 2 ns after the next rising edge. By then, any write from the previous cycle has landed and the inputs are still held. A separate same-cycle probe samples 1 ns after an input change, with no clock edge in between, to show that the input-to-output path holds no register.

// File: rtl/pal_pkg.sv
package pal_pkg;
   // default geometry of the array
   localparam int unsigned DEF_N_IN  = 10;
   localparam int unsigned DEF_N_OUT = 8;
   localparam int unsigned DEF_TERMS = 8;

   // fed-back outputs are all outputs except the two outer ones
   function automatic int unsigned fb_count(input int unsigned n_out);
      return n_out - 2;
   endfunction
endpackage

// File: rtl/pal_fuse_store.sv
module pal_fuse_store #(
   parameter  int unsigned N_FUSE = 2048,
   localparam int unsigned AW     = $clog2(N_FUSE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic              wr_blow,
   output logic [N_FUSE-1:0] fuse_map
);
   // one bit per fuse, 1 = blown; reset leaves every fuse intact
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fuse_map <= '0;
      end else if (wr_en) begin
         fuse_map[wr_addr] <= wr_blow;
      end
   end
endmodule

// File: rtl/pal_term.sv
module pal_term #(
   parameter int unsigned N_COL = 32
) (
   input  logic [N_COL-1:0] blown,
   input  logic [N_COL-1:0] lits,
   output logic             prod
);
   // a blown fuse removes its literal, an intact one keeps it
   assign prod = &(blown | lits);
endmodule

// File: rtl/pal_plane.sv
module pal_plane #(
   parameter  int unsigned N_SIG  = 16,
   parameter  int unsigned N_EVAL = 8,
   parameter  int unsigned TERMS  = 8,
   localparam int unsigned N_COL  = 2 * N_SIG,
   localparam int unsigned N_ROW  = N_EVAL * TERMS,
   localparam int unsigned N_BITS = N_ROW * N_COL
) (
   input  logic [N_BITS-1:0] fuse_map,
   input  logic [N_SIG-1:0]  sig,
   output logic [N_EVAL-1:0] val,
   output logic [N_EVAL-1:0] en
);
   logic [N_COL-1:0] lits;
   logic [N_ROW-1:0] prod;

   // true literal on even column, inverted literal on odd column
   for (genvar s = 0; s < N_SIG; s++) begin : g_lit
      assign lits[2*s]   = sig[s];
      assign lits[2*s+1] = ~sig[s];
   end

   for (genvar r = 0; r < N_ROW; r++) begin : g_row
      pal_term #(.N_COL(N_COL)) u_term (
         .blown (fuse_map[r*N_COL +: N_COL]),
         .lits  (lits),
         .prod  (prod[r])
      );
   end

   // first term of each group is the drive enable, the rest form a NOR
   for (genvar j = 0; j < N_EVAL; j++) begin : g_out
      assign en[j]  = prod[j*TERMS];
      assign val[j] = ~|prod[j*TERMS+1 +: TERMS-1];
   end
endmodule

// File: rtl/pal_array.sv
module pal_array #(
   parameter  int unsigned N_IN   = pal_pkg::DEF_N_IN,
   parameter  int unsigned N_OUT  = pal_pkg::DEF_N_OUT,
   parameter  int unsigned TERMS  = pal_pkg::DEF_TERMS,
   localparam int unsigned N_FB   = pal_pkg::fb_count(N_OUT),
   localparam int unsigned N_SIG  = N_IN + N_FB,
   localparam int unsigned N_COL  = 2 * N_SIG,
   localparam int unsigned N_FUSE = N_COL * N_OUT * TERMS,
   localparam int unsigned AW     = $clog2(N_FUSE)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [AW-1:0]    cfg_addr,
   input  logic             cfg_bit,
   input  logic [N_IN-1:0]  in_pins,
   input  logic [N_FB-1:0]  io_in,
   output logic [N_OUT-1:0] out_val,
   output logic [N_OUT-1:0] out_en
);
   // one seed pass plus one refinement per feedback link
   localparam int unsigned PASSES   = N_FB + 1;
   localparam int unsigned GRP_BITS = N_COL * TERMS;
   localparam int unsigned MID_BITS = N_FB * GRP_BITS;

   if (N_OUT < 3) begin : g_bad_out
      $error("pal_array: N_OUT must be at least 3");
   end
   if (TERMS < 2) begin : g_bad_terms
      $error("pal_array: TERMS must be at least 2");
   end
   if (N_IN < 1) begin : g_bad_in
      $error("pal_array: N_IN must be at least 1");
   end

   logic [N_FUSE-1:0] fuse_map;
   logic [N_FB-1:0]   fb_used;

   pal_fuse_store #(.N_FUSE(N_FUSE)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_addr  (cfg_addr),
      .wr_blow  (cfg_bit),
      .fuse_map (fuse_map)
   );

   // unrolled feedback settling: intermediate passes evaluate only the
   // fed-back outputs, the last pass evaluates every output
   for (genvar p = 0; p < PASSES; p++) begin : g_pass
      logic [N_FB-1:0] fb;

      if (p == 0) begin : g_seed
         assign fb = io_in;
      end else begin : g_refine
         for (genvar k = 0; k < N_FB; k++) begin : g_sel
            assign fb[k] = g_pass[p-1].g_mid.e[k] ? g_pass[p-1].g_mid.v[k] : io_in[k];
         end
      end

      if (p < PASSES - 1) begin : g_mid
         logic [N_FB-1:0] v;
         logic [N_FB-1:0] e;
         pal_plane #(.N_SIG(N_SIG), .N_EVAL(N_FB), .TERMS(TERMS)) u_plane (
            .fuse_map (fuse_map[GRP_BITS +: MID_BITS]),
            .sig      ({fb, in_pins}),
            .val      (v),
            .en       (e)
         );
      end else begin : g_last
         pal_plane #(.N_SIG(N_SIG), .N_EVAL(N_OUT), .TERMS(TERMS)) u_plane (
            .fuse_map (fuse_map),
            .sig      ({fb, in_pins}),
            .val      (out_val),
            .en       (out_en)
         );
      end
   end

   assign fb_used = g_pass[PASSES-1].fb;
endmodule

// File: rtl/pal_array_chk.sv
module pal_array_chk #(
   parameter int unsigned N_OUT  = 8,
   parameter int unsigned N_FB   = 6,
   parameter int unsigned N_FUSE = 2048,
   parameter int unsigned AW     = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [AW-1:0]     cfg_addr,
   input logic              cfg_bit,
   input logic [N_FB-1:0]   io_in,
   input logic [N_OUT-1:0]  out_val,
   input logic [N_OUT-1:0]  out_en,
   input logic [N_FUSE-1:0] fuse_map,
   input logic [N_FB-1:0]   fb_used
);
   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (out_en == '0 && out_val == '1));

   assert_hold_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(fuse_map));

   assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> fuse_map[$past(cfg_addr)] == $past(cfg_bit));

   for (genvar k = 0; k < N_FB; k++) begin : g_fb
      assert_fb_driven_R7: assert property (@(posedge clk) disable iff (!rst_n)
         out_en[k+1] |-> fb_used[k] == out_val[k+1]);
      assert_fb_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !out_en[k+1] |-> fb_used[k] == io_in[k]);
   end
endmodule

bind pal_array pal_array_chk #(
   .N_OUT  (N_OUT),
   .N_FB   (N_FB),
   .N_FUSE (N_FUSE),
   .AW     (AW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_we   (cfg_we),
   .cfg_addr (cfg_addr),
   .cfg_bit  (cfg_bit),
   .io_in    (io_in),
   .out_val  (out_val),
   .out_en   (out_en),
   .fuse_map (fuse_map),
   .fb_used  (fb_used)
);

// File: tb/test_pal_array.sv
`timescale 1ns/1ps
module test_pal_array;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [10:0] cfg_addr = '0;
   logic        cfg_bit = 1'b0;
   logic [9:0]  in_pins = '0;
   logic [5:0]  io_in = '0;
   logic [7:0]  out_val;
   logic [7:0]  out_en;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   typedef struct {
      logic [7:0] v;
      logic [7:0] e;
      string      tag;
   } exp_t;
   exp_t sb[$];

   always #4 clk = ~clk;

   pal_array i_pal_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_addr (cfg_addr),
      .cfg_bit  (cfg_bit),
      .in_pins  (in_pins),
      .io_in    (io_in),
      .out_val  (out_val),
      .out_en   (out_en)
   );

   task automatic compare(input logic [7:0] v, input logic [7:0] e, input string tag);
      n_tests++;
      if (out_val !== v || out_en !== e) begin
         n_fail++;
         $display("FAIL %s: out_val=%h out_en=%h expected out_val=%h out_en=%h",
                  tag, out_val, out_en, v, e);
      end
   endtask

   // monitor: one expectation per cycle, taken after the rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            compare(it.v, it.e, it.tag);
         end
      end
   end

   task automatic wr(input int addr, input logic b);
      @(negedge clk);
      cfg_we   = 1'b1;
      cfg_addr = 11'(addr);
      cfg_bit  = b;
   endtask

   task automatic wr_end();
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // keep only the listed literals of one term (R3 layout), blow the rest
   task automatic set_term(input int o, input int t, input logic [15:0] tm, input logic [15:0] cm);
      for (int c = 0; c < 32; c++) begin
         logic keep;
         keep = (c % 2 == 0) ? tm[c/2] : cm[c/2];
         wr((o*8 + t)*32 + c, ~keep);
      end
      wr_end();
   endtask

   // driver: apply pins and queue the result due after the next edge
   task automatic chk(input logic [9:0] i, input logic [5:0] io,
                      input logic [7:0] v, input logic [7:0] e, input string tag);
      exp_t it;
      @(negedge clk);
      in_pins = i;
      io_in   = io;
      it.v = v; it.e = e; it.tag = tag;
      sb.push_back(it);
   endtask

   // same-cycle probe with no clock edge between stimulus and sample
   task automatic chk_comb(input logic [9:0] i, input logic [5:0] io,
                           input logic [7:0] v, input logic [7:0] e, input string tag);
      @(negedge clk);
      in_pins = i;
      io_in   = io;
      #1;
      compare(v, e, tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      chk(10'h3FF, 6'h3F, 8'hFF, 8'h00, "R1 all intact after reset");

      set_term(0, 0, 16'h0000, 16'h0000);
      chk(10'h000, 6'h00, 8'hFF, 8'h01, "R5 R4 blown term enables out0");

      set_term(0, 1, 16'h0003, 16'h0000);
      chk(10'h003, 6'h00, 8'hFE, 8'h01, "R6 in0&in1 pulls out0 low");
      chk(10'h001, 6'h00, 8'hFF, 8'h01, "R4 partial product stays 0");

      set_term(7, 1, 16'h0000, 16'h0200);
      chk(10'h000, 6'h00, 8'h7F, 8'h01, "R3 complement column of in9");
      chk(10'h200, 6'h00, 8'hFF, 8'h01, "R3 complement column of in9 high");
      chk_comb(10'h203, 6'h00, 8'hFE, 8'h01, "R8 same-cycle response");

      set_term(2, 1, 16'h0010, 16'h0010);
      chk(10'h010, 6'h00, 8'h7F, 8'h01, "R4 conflicting literals give 0");

      @(negedge clk);
      cfg_we = 1'b0; cfg_addr = 11'd32; cfg_bit = 1'b1;
      chk(10'h002, 6'h00, 8'h7F, 8'h01, "R2 strobe low leaves map");
      wr(32, 1'b1); wr_end();
      chk(10'h002, 6'h00, 8'h7E, 8'h01, "R2 blown fuse drops in0");
      wr(32, 1'b0); wr_end();
      chk(10'h002, 6'h00, 8'h7F, 8'h01, "R2 fuse restored");

      set_term(1, 0, 16'h0020, 16'h0000);
      set_term(1, 1, 16'h0040, 16'h0000);
      set_term(3, 0, 16'h0000, 16'h0000);
      set_term(3, 1, 16'h0400, 16'h0000);
      chk(10'h000, 6'h01, 8'h77, 8'h09, "R7 disabled pin feeds io high");
      chk(10'h000, 6'h00, 8'h7F, 8'h09, "R7 disabled pin feeds io low");
      chk(10'h060, 6'h01, 8'h7D, 8'h0B, "R7 driven low overrides io");
      chk(10'h020, 6'h00, 8'h77, 8'h0B, "R7 driven high overrides io");
      chk_comb(10'h060, 6'h01, 8'h7D, 8'h0B, "R8 feedback path same cycle");

      set_term(2, 0, 16'h0000, 16'h0000);
      set_term(2, 2, 16'h1000, 16'h0000);
      chk(10'h020, 6'h00, 8'h77, 8'h0F, "R9 two-link chain");
      chk(10'h060, 6'h3F, 8'h79, 8'h0F, "R9 chain ignores io of driven pins");
      chk(10'h000, 6'h3F, 8'h77, 8'h0D, "R9 chain seeded from io");

      while (sb.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule